// File: doc/BRIEF.md
# Transparent Serial Transmitter with Underrun Stop

This block sends characters of 4 to 16 bits as an unframed serial bit stream. A character enters as a parallel word through a valid/ready handshake. It is shifted onto `txd`, one bit for each pulse of the bit-clock enable `bit_en`. The transmit side of a 16-bit mode register sets the character length and the bit order. Characters within one buffer follow each other with no gap. The last character of a buffer is flagged with `dat_last`.

When the next character of a buffer is not offered at the moment the current one finishes, the block stops. It closes the buffer with an underrun mark and sets a sticky error event, which drives `irq` when `irq_en` is high. The block then stays halted, with the line held high, until a `restart` pulse arrives. Status bits are cleared by pulsing the matching `st_clr` bit.

Top module: `tser_tx`

## Requirements
- R1: After reset the mode register is all zeros, `txd` is 1, `dat_ready` is 0, and `unr_st`, `txe_ev`, `irq`, `halted` and `buf_close` are 0.
- R2: Mode bits 14:11 hold a length code L. For L from 3 to 15, each character is L+1 bits long. Word bits at or above L+1 are not sent.
- R3: Length codes 0, 1 and 2 give 4-bit characters.
- R4: With mode bit 8 at 0, bit 0 of the word is sent first. With mode bit 8 at 1, bit L of the word (the top bit of the character) is sent first.
- R5: A character is accepted only on a `bit_en` cycle. Its first bit appears on `txd` at the edge that accepts it, and each later bit follows at the next `bit_en` edge. The next character of the same buffer is accepted at the edge that ends the previous one, so no idle bit falls between them.
- R6: When the character marked `dat_last` has been sent, `buf_close` pulses for one cycle, `txd` returns to 1, and no error is set.
- R7: If no valid character is offered at the edge that ends a character not marked last, the block signals an underrun. At that edge it pulses `buf_close`, sets `unr_st` and `txe_ev`, enters the halted state and drives `txd` to 1.
- R8: `irq` is 1 exactly when `txe_ev` is set and `irq_en` is 1.
- R9: While halted, `dat_ready` is 0 and `txd` is 1. A `restart` pulse leaves the halted state. A `restart` pulse at any other time has no effect.
- R10: While idle between buffers, no underrun is flagged however long `dat_valid` stays low.
- R11: While mode bit 1 (transmit enable) is 0, `txd` is 1, `dat_ready` is 0 and no underrun is flagged. Clearing this bit part-way through a character drops that character without an error.
- R12: `unr_st` and `txe_ev` stay set until `st_clr[0]` or `st_clr[1]` respectively is 1 at a clock edge.
- R13: Only mode bits 14:11, 8 and 1 affect transmission. All other mode bits have no effect on the transmitted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wd | input | 16 | Mode register write data |
| bit_en | input | 1 | Bit-clock enable, one pulse per bit period |
| dat_valid | input | 1 | Character word offered |
| dat_word | input | 16 | Character word, right-aligned |
| dat_last | input | 1 | Offered character ends the buffer |
| dat_ready | output | 1 | Character accepted this cycle when valid |
| restart | input | 1 | Restart command pulse after an underrun |
| irq_en | input | 1 | Transmit-error interrupt enable |
| st_clr | input | 2 | Clear pulses: bit 0 for `unr_st`, bit 1 for `txe_ev` |
| txd | output | 1 | Serial data out, idles high |
| buf_close | output | 1 | One-cycle pulse when a buffer ends, normally or by underrun |
| unr_st | output | 1 | Sticky underrun status |
| txe_ev | output | 1 | Sticky transmit-error event |
| irq | output | 1 | Transmit-error interrupt |
| halted | output | 1 | Transmission stopped until restart |

## Verification
A wrong bit counter or a wrong length clamp shows at the ports within one character. Too many or too few bits go out, and the stream then moves the next character's first bit or fires an underrun one bit period early or late. A bad order flag gives a mirror-image character that the captured stream exposes at once. A halted state that is entered or left in error shows in the same cycle, as `dat_ready` asserting or `txd` dropping low during what should be a halt. A lost sticky bit shows at the next sample of `unr_st` or `txe_ev`.

// File: rtl/tser_tx.sv
module tser_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [15:0] mode_wd,
  input  logic        bit_en,
  input  logic        dat_valid,
  input  logic [15:0] dat_word,
  input  logic        dat_last,
  output logic        dat_ready,
  input  logic        restart,
  input  logic        irq_en,
  input  logic [1:0]  st_clr,
  output logic        txd,
  output logic        buf_close,
  output logic        unr_st,
  output logic        txe_ev,
  output logic        irq,
  output logic        halted
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_HALT} st_t;

  st_t         st;
  logic [3:0]  clen_q;
  logic        rev_q;
  logic        ten_q;
  logic [15:0] shreg;
  logic [3:0]  cnt;
  logic        lastf;
  logic [15:0] ord;

  wire unused_bits = ^{mode_wd[15], mode_wd[10:9], mode_wd[7:2], mode_wd[0]};

  wire [3:0] lenm1   = (clen_q < 4'd3) ? 4'd3 : clen_q;
  wire       chr_end = (st == S_SHIFT) && (cnt == 4'd0);
  wire       take    = dat_valid && dat_ready;
  wire       unr     = ten_q && bit_en && chr_end && !lastf && !dat_valid;

  assign dat_ready = ten_q && bit_en && ((st == S_IDLE) || (chr_end && !lastf));
  assign halted    = (st == S_HALT);
  assign irq       = txe_ev && irq_en;

  always_comb begin
    ord = '0;
    for (int i = 0; i < 16; i++)
      if (i <= int'(lenm1))
        ord[i] = rev_q ? dat_word[lenm1 - 4'(i)] : dat_word[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      clen_q    <= '0;
      rev_q     <= 1'b0;
      ten_q     <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      lastf     <= 1'b0;
      txd       <= 1'b1;
      buf_close <= 1'b0;
      unr_st    <= 1'b0;
      txe_ev    <= 1'b0;
    end else begin
      buf_close <= 1'b0;
      if (mode_we) begin
        clen_q <= mode_wd[14:11];
        rev_q  <= mode_wd[8];
        ten_q  <= mode_wd[1];
      end
      if (st_clr[0]) unr_st <= 1'b0;
      if (st_clr[1]) txe_ev <= 1'b0;

      if (!ten_q) begin
        txd <= 1'b1;
        if (st == S_SHIFT) st <= S_IDLE;
      end else if (take) begin
        txd   <= ord[0];
        shreg <= ord >> 1;
        cnt   <= lenm1;
        lastf <= dat_last;
        st    <= S_SHIFT;
      end else if (unr) begin
        txd       <= 1'b1;
        st        <= S_HALT;
        buf_close <= 1'b1;
        unr_st    <= 1'b1;
        txe_ev    <= 1'b1;
      end else if (bit_en && st == S_SHIFT) begin
        if (cnt != 4'd0) begin
          txd   <= shreg[0];
          shreg <= shreg >> 1;
          cnt   <= cnt - 4'd1;
        end else begin
          txd       <= 1'b1;
          st        <= S_IDLE;
          buf_close <= 1'b1;
        end
      end

      if (st == S_HALT && restart) st <= S_IDLE;
    end
  end
endmodule

// File: rtl/tser_tx_chk.sv
module tser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ten,
  input logic       txd,
  input logic       restart,
  input logic       halted,
  input logic       unr_st,
  input logic       txe_ev,
  input logic       dat_ready,
  input logic       buf_close,
  input logic [1:0] st_clr
);
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !restart |=> halted);

  // R9
  halt_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> txd && !dat_ready);

  // R7
  unr_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unr_st) |-> halted && buf_close);

  // R11
  ten_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |=> txd);

  // R12
  unr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unr_st && !st_clr[0] |=> unr_st);

  // R12
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txe_ev && !st_clr[1] |=> txe_ev);
endmodule

bind tser_tx tser_tx_chk chk (
  .clk(clk), .rst_n(rst_n), .ten(ten_q), .txd(txd), .restart(restart),
  .halted(halted), .unr_st(unr_st), .txe_ev(txe_ev), .dat_ready(dat_ready),
  .buf_close(buf_close), .st_clr(st_clr)
);

// File: tb/tb_tser_tx.sv
`timescale 1ns/1ps
module tb_tser_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [15:0] mode_wd = '0;
  logic        bit_en = 1'b0;
  logic        dat_valid = 1'b0;
  logic [15:0] dat_word = '0;
  logic        dat_last = 1'b0;
  logic        restart = 1'b0;
  logic        irq_en = 1'b1;
  logic [1:0]  st_clr = '0;
  logic        dat_ready, txd, buf_close, unr_st, txe_ev, irq, halted;

  tser_tx dut (.*);

  always #2.5 clk = ~clk;

  logic [1:0] div = '0;
  always @(posedge clk) begin
    div    <= div + 2'd1;
    bit_en <= (div == 2'd2);
  end

  typedef struct packed {
    logic        rev;
    logic [3:0]  clen;
    logic [15:0] word;
    logic [15:0] exp;
    logic [4:0]  n;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 4'd7,  16'hA5C3, 16'h00C3, 5'd8},
    '{1'b1, 4'd7,  16'h0012, 16'h0048, 5'd8},
    '{1'b0, 4'd15, 16'hBEEF, 16'hBEEF, 5'd16},
    '{1'b1, 4'd15, 16'h0001, 16'h8000, 5'd16},
    '{1'b0, 4'd3,  16'hFFF6, 16'h0006, 5'd4},
    '{1'b1, 4'd3,  16'h0001, 16'h0008, 5'd4},
    '{1'b0, 4'd1,  16'h00FD, 16'h000D, 5'd4},
    '{1'b1, 4'd0,  16'h0003, 16'h000C, 5'd4},
    '{1'b0, 4'd11, 16'h1234, 16'h0234, 5'd12},
    '{1'b1, 4'd4,  16'h0016, 16'h000D, 5'd5}
  };

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [15:0] w);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wd = w;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  function automatic logic [15:0] mword(input logic rev, input logic [3:0] clen);
    return {1'b0, clen, 2'b00, rev, 6'b0, 1'b1, 1'b0};
  endfunction

  task automatic send(input logic [15:0] w, input logic last, input int n,
                      output logic [15:0] cap);
    cap = '0;
    dat_word  = w;
    dat_last  = last;
    dat_valid = 1'b1;
    do @(negedge clk); while (!dat_ready);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) dat_valid = 1'b0;
      cap[i] = txd;
      while (!bit_en) @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] cap;
    int seen;
    repeat (4) @(negedge clk);
    dat_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 ready", dat_ready, 0);
    check("R1 status", {unr_st, txe_ev, irq, halted, buf_close}, 0);
    dat_valid = 1'b0;

    for (int k = 0; k < 10; k++) begin
      set_mode(mword(VECS[k].rev, VECS[k].clen));
      send(VECS[k].word, 1'b1, int'(VECS[k].n), cap);
      check(VECS[k].clen < 3 ? "R3 clamp" : (VECS[k].rev ? "R4 msb-first" : "R2 length"),
            cap, VECS[k].exp);
      @(negedge clk);
      check("R6 close", {buf_close, txd, unr_st}, 3'b110);
    end

    // R10: idle between buffers never underruns
    repeat (40) @(negedge clk);
    check("R10 idle", {unr_st, halted, txd}, 3'b001);

    // R13: other mode bits set
    set_mode(16'hBEFF);
    send(16'h005A, 1'b1, 8, cap);
    check("R13 other bits", cap, 16'h005A);

    // R5: two characters back to back
    set_mode(mword(1'b0, 4'd3));
    cap = '0;
    dat_word = 16'h0005; dat_last = 1'b0; dat_valid = 1'b1;
    do @(negedge clk); while (!dat_ready);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) begin dat_word = 16'h000A; dat_last = 1'b1; end
      if (i == 4) dat_valid = 1'b0;
      cap[i] = txd;
      while (!bit_en) @(negedge clk);
    end
    check("R5 back-to-back", cap, 16'h00A5);
    @(negedge clk);
    check("R6 close after two", {buf_close, unr_st}, 2'b10);

    // R9: restart when not halted is ignored
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check("R9 restart idle", halted, 0);

    // R7: underrun
    irq_en = 1'b1;
    send(16'h0003, 1'b0, 4, cap);
    check("R5 first char", cap, 16'h0003);
    @(negedge clk);
    check("R7 underrun", {halted, unr_st, txe_ev, buf_close, txd}, 5'b11111);
    check("R8 irq on", irq, 1);

    // R9: halted holds off data
    dat_valid = 1'b1;
    seen = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (dat_ready || !txd || !halted) seen++;
    end
    dat_valid = 1'b0;
    check("R9 halt holds", seen, 0);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check("R9 restart", halted, 0);

    // R12 / R8: sticky clears
    check("R12 sticky after restart", {unr_st, txe_ev}, 2'b11);
    @(negedge clk); st_clr = 2'b01;
    @(negedge clk); st_clr = 2'b00;
    check("R12 clear unr", {unr_st, txe_ev}, 2'b01);
    irq_en = 1'b0;
    #1;
    check("R8 irq masked", irq, 0);
    @(negedge clk); st_clr = 2'b10;
    @(negedge clk); st_clr = 2'b00;
    check("R12 clear ev", txe_ev, 0);

    send(16'h0009, 1'b1, 4, cap);
    check("R9 resumes", cap, 16'h0009);
    @(negedge clk);

    // R11: transmit disabled
    set_mode(16'h7800);
    dat_valid = 1'b1;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dat_ready || !txd) seen++;
    end
    dat_valid = 1'b0;
    check("R11 disabled", seen, 0);

    // R11: drop enable mid-character
    set_mode(mword(1'b0, 4'd15));
    dat_word = 16'h0000; dat_last = 1'b0; dat_valid = 1'b1;
    do @(negedge clk); while (!dat_ready);
    @(negedge clk); dat_valid = 1'b0;
    repeat (3) @(negedge clk);
    set_mode(16'h7800);
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!txd || halted || unr_st) seen++;
    end
    check("R11 abort", seen, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule